// File: doc/BRIEF.md
# Vectored Two-Class Interrupt Controller

This block gathers 32 interrupt request lines into one status word and drives two interrupt outputs to a processor core. One output is for normal interrupts and one is for critical interrupts. Each source is either edge-triggered or level-triggered. An enable mask gates which pending sources can reach an output, and a critical-select mask decides which of the two outputs each source feeds. For the critical class, the block can also produce a vector address. This address is a programmable base plus a fixed 512-byte stride for each scan step, where the scan runs either upward or downward through the pending critical bits.

Software uses a simple register bus with an offset, a write strobe, write data and combinational read data. There are nine registers:

| Offset | Register |
|--------|----------|
| 0 | status |
| 1 | status-set |
| 2 | enable |
| 3 | critical select |
| 4 | polarity |
| 5 | trigger |
| 6 | masked status |
| 7 | vector |
| 8 | vector configuration |

Both outputs and the vector are registered. They follow any register change one clock later.

Top module: `irq_vec_ctrl`

## Requirements
- R1: Input line n maps to status bit (31 − n). For example, input 0 maps to bit 31 and input 31 maps to bit 0.
- R2: The register offsets are fixed as listed in the table above. A read of any offset above 8 returns zero.
- R3: A write to offset 0 clears each status bit written as 1. It then ORs back every level-triggered source whose input is high at that clock.
- R4: A write to offset 1 ORs the written value into status. The status reads back at offset 0.
- R5: The normal output is high when (status & enable & ~critical) is nonzero. The critical output is high when (status & enable & critical) is nonzero. Both outputs appear one clock after the register change that causes them.
- R6: A read of offset 6 returns status & enable. Writes to offsets 6 and 7 change nothing.
- R7: The vector is the configuration value with bits 1:0 cleared, plus 512 times a step count. When configuration bit 0 is 1, the scan runs from bit 31 downward and the step count is 31 minus the highest pending critical bit. When bit 0 is 0, the scan runs from bit 0 upward and the step count is the index of the lowest pending critical bit. The vector is updated one clock after its inputs change.
- R8: The vector reads zero whenever no enabled critical source is pending.
- R9: A write to offset 8 stores the value with bit 1 forced to 0. When the vector feature is disabled by parameter, offsets 7 and 8 read as zero.
- R10: Reset clears every register and both outputs. The polarity register (offset 4) is plain storage and does not affect the outputs.
- R11: A source whose trigger bit (offset 5) is 0 is level-triggered. Its status bit follows its input, rising and falling, on every input change.
- R12: A source whose trigger bit is 1 is edge-triggered. A rising input (the input compared with its value on the previous clock) sets its status bit. A falling input leaves the bit set. An input held high sets the bit only once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| irqIn | input | 32 | Interrupt request lines, already synchronised |
| busAddr | input | 4 | Register offset |
| busWrEn | input | 1 | Write strobe for one cycle |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr (combinational) |
| irqNormal | output | 1 | Normal-class interrupt output |
| irqCrit | output | 1 | Critical-class interrupt output |

## Verification
The bench clears a level source whose input is still high. A design that simply cleared the bit would drop a live request. It then holds an edge input high across a clear. A design that re-latched on level would set the bit again. It checks the vector in both scan directions with two pending critical bits whose step counts differ. A design that ignores the direction, or scans from the wrong end, would return the other address. The bench also confirms that writes to the masked-status and vector offsets and to the polarity register leave the outputs unchanged. Finally, it checks that a second copy built without the vector feature reads zero at both vector offsets.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  // Register offsets decoded on the bus.
  localparam int OFF_STATUS  = 0;
  localparam int OFF_SET     = 1;
  localparam int OFF_ENABLE  = 2;
  localparam int OFF_CRIT    = 3;
  localparam int OFF_POL     = 4;
  localparam int OFF_TRIG    = 5;
  localparam int OFF_MASKED  = 6;
  localparam int OFF_VECTOR  = 7;
  localparam int OFF_VECCFG  = 8;

  // Write strobes from the control decoder to the datapath.
  typedef struct packed {
    logic wrStatus;
    logic wrSet;
    logic wrEnable;
    logic wrCrit;
    logic wrPolarity;
    logic wrTrigger;
    logic wrVecCfg;
  } irqc_strobe_t;

endpackage

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  output irqc_strobe_t      strobes
);

  always_comb begin
    strobes            = '0;
    strobes.wrStatus   = busWrEn && (busAddr == ADDR_W'(OFF_STATUS));
    strobes.wrSet      = busWrEn && (busAddr == ADDR_W'(OFF_SET));
    strobes.wrEnable   = busWrEn && (busAddr == ADDR_W'(OFF_ENABLE));
    strobes.wrCrit     = busWrEn && (busAddr == ADDR_W'(OFF_CRIT));
    strobes.wrPolarity = busWrEn && (busAddr == ADDR_W'(OFF_POL));
    strobes.wrTrigger  = busWrEn && (busAddr == ADDR_W'(OFF_TRIG));
    strobes.wrVecCfg   = busWrEn && (busAddr == ADDR_W'(OFF_VECCFG));
    // Offsets 6 and 7 are read-only: no strobe is generated for them.
  end

endmodule

// File: rtl/irqc_vecscan.sv
module irqc_vecscan #(
  parameter int NUM_SRC      = 32,
  parameter int STRIDE_SHIFT = 9
) (
  input  logic [NUM_SRC-1:0] critPend,
  input  logic [NUM_SRC-1:0] vecCfg,
  output logic [NUM_SRC-1:0] vecNext
);

  localparam int IDX_W = $clog2(NUM_SRC);

  logic [IDX_W-1:0] lowIdx;
  logic [IDX_W-1:0] highIdx;
  logic [IDX_W-1:0] steps;
  logic [NUM_SRC-1:0] baseAddr;

  always_comb begin
    lowIdx  = '0;
    highIdx = '0;

    // Scanning from the top down, the last hit is the lowest set bit.
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (critPend[i]) lowIdx = IDX_W'(i);
    end

    // Scanning from the bottom up, the last hit is the highest set bit.
    for (int i = 0; i < NUM_SRC; i++) begin
      if (critPend[i]) highIdx = IDX_W'(i);
    end

    // Bit 0 of the configuration selects the scan direction.
    steps    = vecCfg[0] ? (IDX_W'(NUM_SRC - 1) - highIdx) : lowIdx;
    baseAddr = {vecCfg[NUM_SRC-1:2], 2'b00};
    vecNext  = (|critPend) ? (baseAddr + (NUM_SRC'(steps) << STRIDE_SHIFT)) : '0;
  end

endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int NUM_SRC      = 32,
  parameter int ADDR_W       = 4,
  parameter bit HAS_VECTOR   = 1'b1,
  parameter int STRIDE_SHIFT = 9
) (
  input  logic               clk,
  input  logic               rstN,
  input  irqc_strobe_t       strobes,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [NUM_SRC-1:0] busWrData,
  input  logic [NUM_SRC-1:0] irqIn,
  output logic [NUM_SRC-1:0] busRdData,
  output logic               irqNormal,
  output logic               irqCrit
);

  logic [NUM_SRC-1:0] statusQ, enableQ, critQ, polQ, trigQ, vcfgQ, vecQ;
  logic [NUM_SRC-1:0] prevQ;
  logic [NUM_SRC-1:0] inMapped, riseVec, changeVec, levelMask;
  logic [NUM_SRC-1:0] statusNext, critPend, vecNext;
  logic               normalQ, critOutQ;

  // Input line n feeds status bit (NUM_SRC-1-n).
  for (genvar n = 0; n < NUM_SRC; n++) begin : g_map
    assign inMapped[NUM_SRC-1-n] = irqIn[n];
  end

  assign riseVec   = inMapped & ~prevQ;
  assign changeVec = inMapped ^ prevQ;
  assign levelMask = ~trigQ;
  assign critPend  = statusQ & enableQ & critQ;

  always_comb begin
    statusNext = statusQ;

    // Clear written bits, but keep level sources whose input is still high.
    if (strobes.wrStatus) begin
      statusNext = (statusNext & ~busWrData) | (inMapped & levelMask);
    end

    if (strobes.wrSet) begin
      statusNext = statusNext | busWrData;
    end

    // Edge sources latch on a rising input.
    statusNext = statusNext | (riseVec & trigQ);

    // Level sources follow their input whenever it changes.
    statusNext = (statusNext & ~(changeVec & levelMask))
               | (inMapped & changeVec & levelMask);
  end

  if (HAS_VECTOR) begin : g_vec
    irqc_vecscan #(
      .NUM_SRC     (NUM_SRC),
      .STRIDE_SHIFT(STRIDE_SHIFT)
    ) u_scan (
      .critPend(critPend),
      .vecCfg  (vcfgQ),
      .vecNext (vecNext)
    );
  end else begin : g_novec
    assign vecNext = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ  <= '0;
      enableQ  <= '0;
      critQ    <= '0;
      polQ     <= '0;
      trigQ    <= '0;
      vcfgQ    <= '0;
      vecQ     <= '0;
      prevQ    <= '0;
      normalQ  <= 1'b0;
      critOutQ <= 1'b0;
    end else begin
      statusQ <= statusNext;
      prevQ   <= inMapped;

      if (strobes.wrEnable)   enableQ <= busWrData;
      if (strobes.wrCrit)     critQ   <= busWrData;
      if (strobes.wrPolarity) polQ    <= busWrData;
      if (strobes.wrTrigger)  trigQ   <= busWrData;
      if (strobes.wrVecCfg && HAS_VECTOR) begin
        vcfgQ <= busWrData & ~NUM_SRC'(2);
      end

      // Outputs and vector are recomputed from the current registers.
      vecQ     <= vecNext;
      normalQ  <= |(statusQ & enableQ & ~critQ);
      critOutQ <= |critPend;
    end
  end

  always_comb begin
    case (busAddr)
      ADDR_W'(OFF_STATUS), ADDR_W'(OFF_SET): busRdData = statusQ;
      ADDR_W'(OFF_ENABLE):                   busRdData = enableQ;
      ADDR_W'(OFF_CRIT):                     busRdData = critQ;
      ADDR_W'(OFF_POL):                      busRdData = polQ;
      ADDR_W'(OFF_TRIG):                     busRdData = trigQ;
      ADDR_W'(OFF_MASKED):                   busRdData = statusQ & enableQ;
      ADDR_W'(OFF_VECTOR):                   busRdData = vecQ;
      ADDR_W'(OFF_VECCFG):                   busRdData = vcfgQ;
      default:                               busRdData = '0;
    endcase
  end

  assign irqNormal = normalQ;
  assign irqCrit   = critOutQ;

endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_SRC      = 32,
  parameter int ADDR_W       = 4,
  parameter bit HAS_VECTOR   = 1'b1,
  parameter int STRIDE_SHIFT = 9
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic [NUM_SRC-1:0] busWrData,
  output logic [NUM_SRC-1:0] busRdData,
  output logic               irqNormal,
  output logic               irqCrit
);

  irqc_strobe_t strobes;

  irqc_ctrl #(
    .ADDR_W(ADDR_W)
  ) u_ctrl (
    .busWrEn(busWrEn),
    .busAddr(busAddr),
    .strobes(strobes)
  );

  irqc_datapath #(
    .NUM_SRC     (NUM_SRC),
    .ADDR_W      (ADDR_W),
    .HAS_VECTOR  (HAS_VECTOR),
    .STRIDE_SHIFT(STRIDE_SHIFT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .busAddr  (busAddr),
    .busWrData(busWrData),
    .irqIn    (irqIn),
    .busRdData(busRdData),
    .irqNormal(irqNormal),
    .irqCrit  (irqCrit)
  );

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] irqIn,
  input logic [ADDR_W-1:0]  busAddr,
  input logic               busWrEn,
  input logic [NUM_SRC-1:0] busWrData,
  input logic [NUM_SRC-1:0] busRdData,
  input logic               irqNormal,
  input logic               irqCrit,
  input logic [NUM_SRC-1:0] statusQ,
  input logic [NUM_SRC-1:0] enableQ,
  input logic [NUM_SRC-1:0] critQ,
  input logic [NUM_SRC-1:0] trigQ,
  input logic [NUM_SRC-1:0] vecQ
);

  logic [NUM_SRC-1:0] chkMapped;
  logic [NUM_SRC-1:0] chkPrev;

  // Independent copy of the input bit mapping and the previous-input sample.
  for (genvar n = 0; n < NUM_SRC; n++) begin : g_chk_map
    assign chkMapped[NUM_SRC-1-n] = irqIn[n];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chkPrev <= '0;
    else       chkPrev <= chkMapped;
  end

  // R2: offsets above 8 read zero.
  p_rd_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (int'(busAddr) > 8) |-> (busRdData == '0));

  // R3: a clear write never drops a level source whose input is high.
  p_clear_relevel_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && int'(busAddr) == 0)
      |=> (($past(chkMapped & ~trigQ) & ~statusQ) == '0));

  // R4: a status-set write leaves the written edge-source bits set.
  p_set_edge_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && int'(busAddr) == 1)
      |=> (($past(busWrData & trigQ) & ~statusQ) == '0));

  // R5: the normal output follows the gated non-critical status one clock later.
  p_normal_out_r5: assert property (@(posedge clk) disable iff (!rstN)
    irqNormal == $past(|(statusQ & enableQ & ~critQ)));

  // R5: the critical output follows the gated critical status one clock later.
  p_crit_out_r5: assert property (@(posedge clk) disable iff (!rstN)
    irqCrit == $past(|(statusQ & enableQ & critQ)));

  // R8: with no critical request pending, the vector is zero.
  p_vec_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !irqCrit |-> (vecQ == '0));

  // R12: a rising input on an edge source is latched into status.
  p_edge_latch_r12: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(trigQ & chkMapped & ~chkPrev) & ~statusQ) == '0));

endmodule

bind irq_vec_ctrl irqc_checker #(
  .NUM_SRC(NUM_SRC),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .irqIn    (irqIn),
  .busAddr  (busAddr),
  .busWrEn  (busWrEn),
  .busWrData(busWrData),
  .busRdData(busRdData),
  .irqNormal(irqNormal),
  .irqCrit  (irqCrit),
  .statusQ  (u_dp.statusQ),
  .enableQ  (u_dp.enableQ),
  .critQ    (u_dp.critQ),
  .trigQ    (u_dp.trigQ),
  .vecQ     (u_dp.vecQ)
);

// File: tb/irq_vec_ctrl_tb.sv
`timescale 1ns/1ps
module irq_vec_ctrl_tb;

  localparam logic [1:0] K_WR  = 2'd0;
  localparam logic [1:0] K_RD  = 2'd1;
  localparam logic [1:0] K_OUT = 2'd2;

  typedef struct packed {
    logic [1:0]  kind;
    logic [3:0]  addr;
    logic [31:0] data;   // write value, expected read value, or {norm, crit} in bits 1:0
    logic [3:0]  req;
  } row_t;

  localparam int NROWS = 33;
  localparam row_t TABLE [NROWS] = '{
    '{K_WR,  4'd1,  32'h8080_0010, 4'd4},  // R4 set three bits
    '{K_RD,  4'd0,  32'h8080_0010, 4'd4},  // R4 readback
    '{K_WR,  4'd2,  32'h8000_0000, 4'd6},  // enable bit 31
    '{K_RD,  4'd6,  32'h8000_0000, 4'd6},  // R6 masked status
    '{K_OUT, 4'd0,  32'h0000_0002, 4'd5},  // R5 normal only
    '{K_WR,  4'd3,  32'h8000_0000, 4'd5},  // bit 31 critical
    '{K_RD,  4'd3,  32'h8000_0000, 4'd2},  // R2 critical-select offset
    '{K_OUT, 4'd0,  32'h0000_0001, 4'd5},  // R5 critical only
    '{K_WR,  4'd2,  32'h8080_0010, 4'd5},
    '{K_WR,  4'd3,  32'h0080_0010, 4'd5},
    '{K_WR,  4'd8,  32'h1234_0003, 4'd9},  // R9 bit 1 dropped
    '{K_RD,  4'd8,  32'h1234_0001, 4'd9},
    '{K_RD,  4'd7,  32'h1234_1000, 4'd7},  // R7 downward: bit 23, 8 steps
    '{K_OUT, 4'd0,  32'h0000_0003, 4'd5},  // R5 both
    '{K_WR,  4'd8,  32'h1234_0000, 4'd7},
    '{K_RD,  4'd4,  32'h0000_0000, 4'd10},
    '{K_RD,  4'd7,  32'h1234_0800, 4'd7},  // R7 upward: bit 4, 4 steps
    '{K_WR,  4'd7,  32'hFFFF_FFFF, 4'd6},  // R6 ignored write
    '{K_WR,  4'd6,  32'hFFFF_FFFF, 4'd6},  // R6 ignored write
    '{K_RD,  4'd7,  32'h1234_0800, 4'd6},
    '{K_RD,  4'd6,  32'h8080_0010, 4'd6},
    '{K_WR,  4'd4,  32'hA5A5_A5A5, 4'd10}, // R10 polarity storage
    '{K_RD,  4'd4,  32'hA5A5_A5A5, 4'd10},
    '{K_OUT, 4'd0,  32'h0000_0003, 4'd10}, // R10 no effect on outputs
    '{K_WR,  4'd0,  32'h0080_0010, 4'd3},  // R3 clear low level sources
    '{K_RD,  4'd0,  32'h8000_0000, 4'd3},
    '{K_RD,  4'd7,  32'h0000_0000, 4'd8},  // R8 vector idle
    '{K_OUT, 4'd0,  32'h0000_0002, 4'd5},
    '{K_RD,  4'd9,  32'h0000_0000, 4'd2},  // R2 unused offset
    '{K_RD,  4'd15, 32'h0000_0000, 4'd2},  // R2 unused offset
    '{K_WR,  4'd0,  32'h8000_0000, 4'd3},
    '{K_RD,  4'd0,  32'h0000_0000, 4'd3},
    '{K_OUT, 4'd0,  32'h0000_0000, 4'd5}
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] irqIn;
  logic [3:0]  busAddr;
  logic        busWrEn;
  logic [31:0] busWrData;
  logic [31:0] busRdData, rdNv;
  logic        irqNormal, irqCrit, normNv, critNv;

  int  nChecks = 0;
  int  nFail   = 0;
  bit  finished = 1'b0;

  always #4 clk = ~clk;

  irq_vec_ctrl u_dut (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData),
    .irqNormal(irqNormal), .irqCrit(irqCrit)
  );

  irq_vec_ctrl #(.HAS_VECTOR(1'b0)) u_dut_nv (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(rdNv),
    .irqNormal(normNv), .irqCrit(critNv)
  );

  task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL R%0d: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input int req);
    busAddr = a;
    #1;
    chk(req, busRdData, exp);
    @(negedge clk);
  endtask

  task automatic outs(input logic n, input logic c, input int req);
    #1;
    chk(req, {30'd0, irqNormal, irqCrit}, {30'd0, n, c});
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    rstN = 1'b0; irqIn = '0; busAddr = '0; busWrEn = 1'b0; busWrData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10: every register and both outputs are zero after reset.
    for (int a = 0; a < 9; a++) rd(4'(a), 32'h0, 10);
    outs(1'b0, 1'b0, 10);

    // Table walk over register behaviour, inputs idle.
    for (int i = 0; i < NROWS; i++) begin
      busAddr = TABLE[i].addr;
      if (TABLE[i].kind == K_WR) begin
        busWrData = TABLE[i].data;
        busWrEn   = 1'b1;
      end
      #1;
      if (TABLE[i].kind == K_RD) begin
        chk(int'(TABLE[i].req), busRdData, TABLE[i].data);
      end else if (TABLE[i].kind == K_OUT) begin
        chk(int'(TABLE[i].req), {30'd0, irqNormal, irqCrit}, TABLE[i].data);
      end
      @(negedge clk);
      busWrEn = 1'b0;
    end

    // R9: the copy without vector support reads zero at offsets 7 and 8.
    busAddr = 4'd8; #1; chk(9, rdNv, 32'h0);
    busAddr = 4'd7; #1; chk(9, rdNv, 32'h0);
    busAddr = 4'd2; #1; chk(2, rdNv, 32'h8080_0010);
    @(negedge clk);

    // R1, R11: input 0 is level-triggered and lands in bit 31.
    irqIn = 32'h0000_0001;
    @(negedge clk);
    rd(4'd0, 32'h8000_0000, 1);
    outs(1'b1, 1'b0, 5);
    // R3: clearing a still-high level source leaves it set.
    wr(4'd0, 32'h8000_0000);
    rd(4'd0, 32'h8000_0000, 3);
    // R11: the level source follows its input low.
    irqIn = '0;
    @(negedge clk);
    rd(4'd0, 32'h0, 11);
    // R1: input 31 lands in bit 0.
    irqIn = 32'h8000_0000;
    @(negedge clk);
    rd(4'd0, 32'h0000_0001, 1);
    irqIn = '0;
    @(negedge clk);
    rd(4'd0, 32'h0, 11);

    // R12: input 31 made edge-triggered; a pulse stays latched.
    wr(4'd5, 32'h0000_0001);
    rd(4'd5, 32'h0000_0001, 2);
    irqIn = 32'h8000_0000;
    @(negedge clk);
    irqIn = '0;
    @(negedge clk);
    rd(4'd0, 32'h0000_0001, 12);
    wr(4'd0, 32'h0000_0001);
    rd(4'd0, 32'h0, 12);
    // R12: an input held high sets the bit only once.
    irqIn = 32'h8000_0000;
    @(negedge clk);
    rd(4'd0, 32'h0000_0001, 12);
    wr(4'd0, 32'h0000_0001);
    repeat (3) @(negedge clk);
    rd(4'd0, 32'h0, 12);
    // R4: status-set on an edge source is kept.
    wr(4'd1, 32'h0000_0001);
    rd(4'd0, 32'h0000_0001, 4);

    // R10: reset in mid-run clears everything again.
    irqIn = '0;
    rstN  = 1'b0;
    @(negedge clk);
    rstN  = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 9; a++) rd(4'(a), 32'h0, 10);
    outs(1'b0, 1'b0, 10);

    finish_run();
  end

endmodule